// File: doc/BRIEF.md
# Stereo Zero-Data Detector

This block watches a stereo sample stream, one left/right pair of signed 24-bit words per frame, and raises a silence flag once both channels have been exactly zero for a long unbroken run of frames. Downstream logic can use the flag to power down an output stage or to signal that the source has gone quiet. Any nonzero sample on either channel drops the flag on the frame where that sample is seen.

A frame is presented by pulsing `frame_vld` for one clock with both words valid on `smp_left` and `smp_right`. The block never applies back-pressure: it accepts every frame it is offered, so it has no ready output, and a cycle without `frame_vld` carries no frame. The `quiet_hold` input is driven high while the surrounding converter is powered down or held in reset because its clocks have stopped. While it is high the flag is forced low and the run count is discarded, so after release a full new run is needed.

The run length is the parameter `RUN_LEN`, 8192 frames by default. The run counter is just wide enough to hold `RUN_LEN` and stops at that value.

Top module: `zdet_stereo`

## Requirements
- R1: After reset `quiet_flag` is 0 and the run count is empty.
- R2: `quiet_flag` rises in the clock after the edge that accepts the `RUN_LEN`-th consecutive frame in which both channels are zero. After `RUN_LEN`-1 such frames it is still 0.
- R3: A frame whose left word, right word or both are nonzero sets `quiet_flag` to 0 in the clock after the edge that accepts it, and restarts the run from zero.
- R4: The run count stops at `RUN_LEN`. During silence of any length beyond that, `quiet_flag` stays 1 and does not wrap back to 0.
- R5: While `quiet_hold` is 1, `quiet_flag` is 0 from the next clock onward, and frames have no effect.
- R6: After `quiet_hold` falls, the run starts from zero. `RUN_LEN` further all-zero frames are needed before `quiet_flag` rises.
- R7: Cycles with `frame_vld` = 0 are ignored whatever the sample inputs carry. They neither advance nor break the run, and `quiet_flag` holds its value.
- R8: A word counts as nonzero if any single one of its 24 bits is 1. Both words are judged together on the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-clock strobe: a frame is present on the sample inputs |
| smp_left | input | 24 | Left-channel sample, two's complement |
| smp_right | input | 24 | Right-channel sample, two's complement |
| quiet_hold | input | 1 | High during power-down or clock-stop reset; forces the flag low |
| quiet_flag | output | 1 | Registered silence flag |

## Verification
Every result of this block is due exactly one clock after the edge that takes in its cause: a frame strobe, a hold level or an idle cycle. Nothing sits in a pipeline between the run counter and the flag. The bench drives each stimulus on the falling edge, lets one rising edge pass, and samples `quiet_flag` 1 ns later. It compares the flag with a run count kept arithmetically in the bench. The bench is built with a short run length so that it can sweep every bit of both channels and walk exactly to the threshold and past the point where an unsaturated counter would wrap.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LEFT = 0;
  localparam int unsigned CH_RIGHT = 1;
  typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/zdet_chan_zero.sv
module zdet_chan_zero #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                is_zero
);
  always_comb is_zero = ~(|sample);
endmodule

// File: rtl/zdet_run_counter.sv
module zdet_run_counter #(
  parameter int unsigned RUN_LEN = 8192,
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             one_short
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(RUN_LEN - 1);

  always_comb begin
    full      = (count == LIMIT);
    one_short = (count == LIMIT_M1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (clear)           count <= '0;
    else if (advance && !full) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/zdet_stereo.sv
module zdet_stereo #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                quiet_hold,
  output logic                quiet_flag
);
  import zdet_pkg::*;
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [SAMPLE_W-1:0] ch_data [NUM_CH];
  ch_mask_t            ch_zero;
  logic                both_zero, run_clear, run_adv;
  logic                run_full, run_one_short;
  logic [CNT_W-1:0]    run_count;
  logic                flag_q;

  always_comb begin
    ch_data[CH_LEFT]  = smp_left;
    ch_data[CH_RIGHT] = smp_right;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    zdet_chan_zero #(.SAMPLE_W(SAMPLE_W)) u_zero (
      .sample  (ch_data[c]),
      .is_zero (ch_zero[c])
    );
  end

  always_comb begin
    both_zero = &ch_zero;
    run_clear = quiet_hold | (frame_vld & ~both_zero);
    run_adv   = frame_vld & both_zero;
  end

  zdet_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (run_clear),
    .advance   (run_adv),
    .count     (run_count),
    .full      (run_full),
    .one_short (run_one_short)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (run_clear) flag_q <= 1'b0;
    else if (run_adv)   flag_q <= run_full | run_one_short;
  end

  assign quiet_flag = flag_q;
endmodule

// File: rtl/zdet_stereo_checker.sv
module zdet_stereo_checker #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192,
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_vld,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic [SAMPLE_W-1:0] smp_right,
  input logic                quiet_hold,
  input logic                quiet_flag,
  input logic [CNT_W-1:0]    run_count
);
  p_nonzero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && ((smp_left != '0) || (smp_right != '0))) |=> !quiet_flag);

  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_hold |=> !quiet_flag);

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_vld && !quiet_hold) |=> $stable(quiet_flag));

  p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiet_flag) |-> $past(frame_vld && smp_left == '0 && smp_right == '0 && !quiet_hold));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_count <= CNT_W'(RUN_LEN));

  p_flag_means_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_flag |-> (run_count == CNT_W'(RUN_LEN)));
endmodule

bind zdet_stereo zdet_stereo_checker #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_vld  (frame_vld),
  .smp_left   (smp_left),
  .smp_right  (smp_right),
  .quiet_hold (quiet_hold),
  .quiet_flag (quiet_flag),
  .run_count  (run_count)
);

// File: tb/zdet_stereo_bench.sv
`timescale 1ns/1ps
module zdet_stereo_bench;
  localparam int W = 24;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0, frame_vld = 1'b0, quiet_hold = 1'b0;
  logic [W-1:0] smp_left = '0, smp_right = '0;
  logic quiet_flag;
  int total = 0, bad = 0, run = 0;

  always #2 clk = ~clk;

  zdet_stereo #(.SAMPLE_W(W), .RUN_LEN(N)) u_zdet_stereo (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .smp_left(smp_left),
    .smp_right(smp_right), .quiet_hold(quiet_hold), .quiet_flag(quiet_flag)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (quiet_flag !== exp) begin
      bad++;
      $display("FAIL %s: quiet_flag=%b expected=%b run=%0d", tag, quiet_flag, exp, run);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [W-1:0] l,
                      input logic [W-1:0] r, input logic h);
    @(negedge clk);
    frame_vld = v; smp_left = l; smp_right = r; quiet_hold = h;
    if (h) run = 0;
    else if (v) run = (l == 0 && r == 0) ? ((run < N) ? run + 1 : N) : 0;
    @(posedge clk); #1;
    check(tag, (run == N));
  endtask

  task automatic zeros(input string tag, input int k);
    for (int i = 0; i < k; i++) step(tag, 1'b1, '0, '0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset", 1'b0);

    zeros("R2 below threshold", N - 1);
    check("R2 one short", 1'b0);
    zeros("R2 threshold", 1);
    check("R2 reached", 1'b1);
    zeros("R4 saturate", 3 * N);

    for (int k = 0; k < 4; k++) step("R7 idle nonzero", 1'b0, 24'h800000, 24'h000001, 1'b0);
    step("R3 left nonzero", 1'b1, 24'h7FFFFF, '0, 1'b0);
    zeros("R2 refill", N);
    step("R3 right nonzero", 1'b1, '0, 24'h800000, 1'b0);
    zeros("R2 refill", N);
    step("R3 both nonzero", 1'b1, 24'h123456, 24'hFEDCBA, 1'b0);

    zeros("R7 partial", N - 1);
    for (int k = 0; k < 5; k++) step("R7 idle zero", 1'b0, '0, '0, 1'b0);
    zeros("R7 completes", 1);

    for (int ch = 0; ch < 2; ch++)
      for (int b = 0; b < W; b++) begin
        zeros("R8 fill", N);
        step("R8 single bit", 1'b1, ch == 0 ? (24'h1 << b) : '0,
             ch == 1 ? (24'h1 << b) : '0, 1'b0);
      end

    zeros("R5 fill", N);
    for (int k = 0; k < 4; k++) step("R5 hold", 1'b1, '0, '0, 1'b1);
    zeros("R6 restart", N - 1);
    check("R6 not early", 1'b0);
    zeros("R6 full again", 1);
    zeros("R5 mid fill", N / 2);
    step("R5 hold mid run", 1'b0, '0, '0, 1'b1);
    zeros("R6 after mid hold", N);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule